// File: doc/BRIEF.md
# EDO DRAM Access Cycle Sequencer

This block turns single memory requests into the strobe sequence an EDO DRAM expects. It works at one clock rate for one speed grade of part, so every delay is a constant clock count set by parameter, not a run-time setting. Each request carries a row, a column, a direction bit and a page-continue flag. The block puts the row on the multiplexed address bus and drops RAS#. It then puts the column on the bus and gives one CAS# pulse, with WE# low around that pulse for writes.

After an access the row stays open. A later request that sets the page-continue flag and names the same row gets only a new column and CAS# pulse. Any other request closes the row. RAS# goes high only once its minimum low time has passed, and the precharge time runs before the new row opens. The requester presents a request with `req_valid`, and the block takes it on a clock edge where `req_ready` is high.

Top module: `edo_seq`

## Requirements
- R1: After reset, `ras_n`, `cas_n` and `we_n` are high and `req_ready` is high.
- R2: When a row opens, `ma` carries the requested row in the clock before RAS# falls and in the clock in which it falls.
- R3: For each row opening, the first CAS# falls exactly `T_RCD` (default 3) clocks after RAS# falls, and CAS# is only low while RAS# is low.
- R4: Each CAS# low pulse lasts exactly one clock. `ma` carries the request's column in that clock and in the clock before it.
- R5: For a write (`req_write`=1), `we_n` is low in the CAS# low clock and in the clock before it. For a read it is high in both.
- R6: A request taken while a row is open, with `req_page`=1 and the same row, produces no RAS# activity. Its CAS# falls 2 clocks after the edge that takes it.
- R7: Any other request taken while a row is open closes the row. RAS# then stays high for at least `T_RP` (default 3) clocks before it falls again. With default timings, CAS# falls 7 clocks after the edge that takes the request.
- R8: RAS# stays low for at least `T_RAS` (default 5) consecutive clocks each time it falls, including across page-mode accesses.
- R9: `req_ready` is high only when no access is in flight, meaning the block is idle or a row is open with CAS# high. A request from idle has its CAS# fall 5 clocks after the edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request is taken on this edge if valid |
| req_row | input | AW | Row address of the request |
| req_col | input | AW | Column address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_page | input | 1 | Page-continue: reuse the open row if it matches |
| ma | output | AW | Multiplexed DRAM address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |

## Verification
The hardest case to reach is a row closing at the earliest clock allowed. A miss must arrive in the first cycle `req_ready` rises after an opening, so the RAS# low-time limit and the precharge count decide when the strobes move. The bench issues each request at the first ready cycle. Random row choices among four values, mixed with random page flags, make hits, same-row closes and different-row closes follow one another directly. A monitor at the pins measures every RAS# and CAS# run length.

// File: rtl/edo_seq.sv
module edo_seq #(
  parameter int AW    = 11,
  parameter int T_RP  = 3,
  parameter int T_RAS = 5,
  parameter int T_RCD = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_row,
  input  logic [AW-1:0] req_col,
  input  logic          req_write,
  input  logic          req_page,
  output logic [AW-1:0] ma,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n
);
  localparam int CW = $clog2(T_RAS + T_RP + T_RCD + 1);

  typedef enum logic [2:0] {IDLE, ROWA, RASD, COLA, CASL, OPEN, WRAS, PRE} st_t;
  st_t st;

  logic [CW-1:0] cnt, rlow;
  logic [AW-1:0] row_q, col_q;
  logic          wr_q;

  wire take   = req_valid && req_ready;
  wire hit    = req_page && (req_row == row_q);
  wire ras_ok = rlow >= CW'(T_RAS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= IDLE;
      cnt   <= '0;
      rlow  <= '0;
      row_q <= '0;
      col_q <= '0;
      wr_q  <= 1'b0;
    end else begin
      if (take) begin
        row_q <= req_row;
        col_q <= req_col;
        wr_q  <= req_write;
      end
      rlow <= ras_n ? '0 : (ras_ok ? rlow : rlow + 1'b1);
      case (st)
        IDLE: if (take) st <= ROWA;
        ROWA: begin st <= RASD; cnt <= CW'(T_RCD - 2); end
        RASD: if (cnt == '0) st <= COLA; else cnt <= cnt - 1'b1;
        COLA: st <= CASL;
        CASL: st <= OPEN;
        OPEN: if (take) begin
          if (hit) st <= COLA;
          else if (ras_ok) begin st <= PRE; cnt <= CW'(T_RP - 2); end
          else st <= WRAS;
        end
        WRAS: if (ras_ok) begin st <= PRE; cnt <= CW'(T_RP - 2); end
        PRE:  if (cnt == '0) st <= ROWA; else cnt <= cnt - 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  assign req_ready = (st == IDLE) || (st == OPEN);
  assign ras_n     = (st == IDLE) || (st == ROWA) || (st == PRE);
  assign cas_n     = (st != CASL);
  assign we_n      = !(wr_q && ((st == COLA) || (st == CASL)));
  assign ma        = ((st == ROWA) || (st == RASD)) ? row_q : col_q;
endmodule

module edo_seq_chk #(
  parameter int AW    = 11,
  parameter int T_RP  = 3,
  parameter int T_RAS = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic [AW-1:0] ma,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n
);
  localparam int KW = $clog2(T_RAS + T_RP + 2);
  logic [KW-1:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= KW'(T_RP);
    end else begin
      lo_cnt <= ras_n ? '0 : ((lo_cnt >= KW'(T_RAS)) ? lo_cnt : lo_cnt + 1'b1);
      hi_cnt <= !ras_n ? '0 : ((hi_cnt >= KW'(T_RP)) ? hi_cnt : hi_cnt + 1'b1);
    end
  end

  p_ras_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> lo_cnt >= KW'(T_RAS));
  p_precharge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> hi_cnt >= KW'(T_RP));
  p_cas_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |=> cas_n);
  p_col_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $stable(ma));
  p_we_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $stable(we_n));
  p_cas_in_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);
  p_row_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $stable(ma));
  p_ready_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cas_n && we_n);
endmodule

bind edo_seq edo_seq_chk #(.AW(AW), .T_RP(T_RP), .T_RAS(T_RAS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .ma(ma),
  .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n));

// File: tb/edo_seq_tb.sv
`timescale 1ns/1ps
module edo_seq_tb;
  localparam int AW = 11;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_page = 0;
  logic [AW-1:0] req_row = '0, req_col = '0;
  logic req_ready, ras_n, cas_n, we_n;
  logic [AW-1:0] ma;

  int tests = 0, fails = 0;
  bit done = 0, mon_on = 0;
  bit open = 0;
  logic [AW-1:0] open_row = '0, exp_row = '0;

  always #2 clk = ~clk;

  edo_seq #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .req_write(req_write),
    .req_page(req_page), .ma(ma), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_lat(input bit is_open, input bit pg, input bit same);
    if (!is_open) return 5;
    if (pg && same) return 2;
    return 7;
  endfunction

  logic prev_ras = 1, prev_cas = 1, prev_we = 1, pend = 0;
  logic [AW-1:0] prev_ma = '0;
  int hi_run = 100, lo_run = 0, since = 0;

  always @(negedge clk) if (mon_on) begin
    if (prev_ras && !ras_n) begin
      check(hi_run >= 3, "R7 precharge", hi_run, 3);
      check(ma == prev_ma && ma == exp_row, "R2 row setup", int'(ma), int'(exp_row));
      since = 0;
      pend = 1;
    end
    if (!prev_ras && ras_n) check(lo_run >= 5, "R8 ras low width", lo_run, 5);
    if (prev_cas && !cas_n) begin
      if (pend) begin
        check(since == 3, "R3 ras to cas", since, 3);
        pend = 0;
      end
      check(!ras_n, "R3 cas inside row", int'(ras_n), 0);
      check(ma == prev_ma, "R4 column setup", int'(ma), int'(prev_ma));
      check(we_n == prev_we, "R5 we setup", int'(we_n), int'(prev_we));
    end
    if (!prev_cas) check(cas_n, "R4 cas pulse one clock", int'(cas_n), 1);
    hi_run = ras_n ? (prev_ras ? hi_run + 1 : 1) : 0;
    lo_run = !ras_n ? (!prev_ras ? lo_run + 1 : 1) : 0;
    since++;
    prev_ras = ras_n; prev_cas = cas_n; prev_we = we_n; prev_ma = ma;
  end

  task automatic do_req(input logic [AW-1:0] row, input logic [AW-1:0] col,
                        input bit wr, input bit pg);
    int lat, want;
    bit hitc, busy_ok;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    hitc = open && pg && (row == open_row);
    want = exp_lat(open, pg, row == open_row);
    if (!hitc) exp_row = row;
    req_row = row; req_col = col; req_write = wr; req_page = pg; req_valid = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    busy_ok = 1;
    while (cas_n && lat < 20) begin
      if (req_ready) busy_ok = 0;
      @(negedge clk);
      lat++;
    end
    if (req_ready) busy_ok = 0;
    check(busy_ok, "R9 ready low in flight", int'(busy_ok), 1);
    if (hitc) check(lat == want, "R6 page hit latency", lat, want);
    else if (open) check(lat == want, "R7 row miss latency", lat, want);
    else check(lat == want, "R9 idle latency", lat, want);
    check(ma == col, "R4 column value", int'(ma), int'(col));
    check(we_n == !wr, "R5 we level", int'(we_n), int'(!wr));
    open = 1;
    open_row = row;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [AW-1:0] rows [4];
    seed = 12345;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    check(ras_n && cas_n && we_n, "R1 strobes idle", {ras_n, cas_n, we_n}, 7);
    check(req_ready, "R1 ready after reset", int'(req_ready), 1);
    mon_on = 1;

    do_req(11'h012, 11'h034, 0, 0);
    do_req(11'h012, 11'h035, 1, 1);
    do_req(11'h012, 11'h036, 1, 1);
    do_req(11'h012, 11'h037, 0, 0);
    do_req(11'h7FF, 11'h000, 1, 1);
    do_req(11'h000, 11'h7FF, 0, 1);

    rows[0] = 11'h001; rows[1] = 11'h155; rows[2] = 11'h2AA; rows[3] = 11'h7FE;
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] r, c;
      bit w, p;
      r = rows[$urandom_range(3, 0)];
      c = AW'($urandom);
      w = $urandom_range(1, 0) == 1;
      p = $urandom_range(3, 0) != 0;
      do_req(r, c, w, p);
    end
    repeat (5) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule